// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block is a small, fully associative store of recently taken branches. Each fetch address is compared against every stored branch address. If the whole address matches a valid entry, the block predicts the branch as taken and offers the stored destination as the next fetch address. If no entry matches, it offers the sequential address, which is the fetch address plus a fixed step. Only branches that are predicted taken are held, so a hit always means "taken".

The execute stage reports each resolved branch on a result port. The report gives the branch address, whether the branch was taken, and where it went. The block handles each report as follows:

- A taken branch that was not in the table is inserted. The block uses the lowest free entry if there is one, and otherwise a round-robin victim.
- A stored branch that resolves not taken is deleted.
- A stored branch that went somewhere else has its destination rewritten.

Each of these three events is a misprediction. It starts a two-cycle penalty sequence controlled by a three-state machine:

- `PEN_IDLE` moves to `PEN_FIRST` on a misprediction.
- `PEN_FIRST` moves to `PEN_SECOND`, or restarts in `PEN_FIRST` on a new misprediction.
- `PEN_SECOND` returns to `PEN_IDLE`, or restarts in `PEN_FIRST` on a new misprediction.

The flush output is high in both penalty states. The redirect pulse and the corrected address are valid in `PEN_FIRST`.

Top module: `btb_top`

## Requirements
- R1: A lookup hits only when the whole fetch address equals the address of a valid entry. On a miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + PC_STEP` (PC_STEP = 4), in the same cycle.
- R2: On a hit, `pred_hit` is 1 and `pred_next_pc` is that entry's stored destination, in the same cycle.
- R3: A taken result whose address is not stored is written into the table. A lookup of that address hits from the next cycle on.
- R4: An insertion uses the lowest-numbered free entry. When every entry is valid, it replaces the entry at the round-robin pointer. The pointer starts at 0 after reset and advances by one (wrapping at ENTRIES) only when it is used.
- R5: A not-taken result whose address is stored deletes that entry.
- R6: A taken result whose address is stored with a different destination rewrites that destination.
- R7: A taken result matching a stored entry and its destination, or a not-taken result for an unstored address, leaves the table unchanged and raises no redirect.
- R8: A misprediction (R3, R5 or R6) raises `redirect` for one cycle, in the cycle after the result. In that cycle `redirect_pc` is the actual destination if taken, else branch address + 4. `flush` is high for exactly that cycle and the next.
- R9: A misprediction arriving while a penalty is in progress restarts the two-cycle sequence from its first state.
- R10: A lookup in the same cycle as a result for the same address sees the table as it was before that result.
- R11: After reset, the table is empty and `flush` and `redirect` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_hit | output | 1 | Stored taken branch found |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | Resolved branch report present |
| res_pc | input | PC_W | Address of resolved branch |
| res_taken | input | 1 | Branch was taken |
| res_target | input | PC_W | Actual destination of the branch |
| flush | output | 1 | Wrong-path fetch killed (penalty cycle) |
| redirect | output | 1 | One-cycle restart pulse |
| redirect_pc | output | PC_W | Corrected fetch address, valid with redirect |

## Verification
The prediction outputs are combinational. The bench therefore compares them in the same cycle as the fetch address, half a period after the inputs are applied. Table changes take effect at the clock edge that samples a result. Lookups are checked for the old contents in that cycle and for the new contents from the following cycle.

`redirect` and `redirect_pc` are due one edge after the result. `flush` is due on that edge and the next one. A behavioural model advances at every edge and is compared at every falling edge, so each penalty cycle is checked in the cycle it is due, including restarts.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        PEN_IDLE   = 2'd0,
        PEN_FIRST  = 2'd1,
        PEN_SECOND = 2'd2
    } pen_state_e;
endpackage

// File: rtl/btb_cam.sv
module btb_cam #(
    parameter int N  = 4,
    parameter int W  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  ent_v,
    input  logic [W-1:0]  ent_tag [N],
    input  logic [W-1:0]  key,
    output logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign vec[g] = ent_v[g] && (ent_tag[g] == key);
    end

    assign hit = |vec;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  ent_v,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] vic,
    output logic          use_rr
);
    logic          found;
    logic [IW-1:0] free_idx;

    always_comb begin
        found    = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_v[i]) begin
                found    = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    assign use_rr = !found;
    assign vic    = found ? free_idx : rr_ptr;
endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 4,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    output logic            flush,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_pc
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [ENTRIES-1:0] ent_v;
    logic [PC_W-1:0]    ent_tag [ENTRIES];
    logic [PC_W-1:0]    ent_tgt [ENTRIES];
    logic [IW-1:0]      rr_ptr;

    logic [ENTRIES-1:0] lk_vec, up_vec;
    logic               lk_hit, up_hit;
    logic [IW-1:0]      lk_idx, up_idx;
    logic [IW-1:0]      vic;
    logic               use_rr;
    logic               misp;
    logic               do_ins;

    pen_state_e state, state_nx;

    btb_cam #(.N(ENTRIES), .W(PC_W), .IW(IW)) u_lk_cam (
        .ent_v(ent_v), .ent_tag(ent_tag), .key(fetch_pc),
        .vec(lk_vec), .hit(lk_hit), .idx(lk_idx)
    );

    btb_cam #(.N(ENTRIES), .W(PC_W), .IW(IW)) u_up_cam (
        .ent_v(ent_v), .ent_tag(ent_tag), .key(res_pc),
        .vec(up_vec), .hit(up_hit), .idx(up_idx)
    );

    btb_victim #(.N(ENTRIES), .IW(IW)) u_vic (
        .ent_v(ent_v), .rr_ptr(rr_ptr), .vic(vic), .use_rr(use_rr)
    );

    // Lookup path (combinational, sees contents before this cycle's result)
    assign pred_hit     = lk_hit;
    assign pred_next_pc = lk_hit ? ent_tgt[lk_idx] : fetch_pc + PC_W'(PC_STEP);

    // Result classification
    assign do_ins = res_valid && res_taken && !up_hit;
    always_comb begin
        misp = 1'b0;
        if (res_valid) begin
            if (up_hit) misp = !res_taken || (ent_tgt[up_idx] != res_target);
            else        misp = res_taken;
        end
    end

    // Valid bits and round-robin pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            rr_ptr <= '0;
        end else if (res_valid) begin
            if (up_hit && !res_taken) begin
                ent_v[up_idx] <= 1'b0;
            end else if (do_ins) begin
                ent_v[vic] <= 1'b1;
                if (use_rr) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    // Tag and destination storage
    always_ff @(posedge clk) begin
        if (do_ins) begin
            ent_tag[vic] <= res_pc;
            ent_tgt[vic] <= res_target;
        end else if (res_valid && up_hit && res_taken) begin
            ent_tgt[up_idx] <= res_target;
        end
    end

    // Penalty state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= PEN_IDLE;
            redirect_pc <= '0;
        end else begin
            state <= state_nx;
            if (misp) redirect_pc <= res_taken ? res_target : res_pc + PC_W'(PC_STEP);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PEN_IDLE:   state_nx = misp ? PEN_FIRST : PEN_IDLE;
            PEN_FIRST:  state_nx = misp ? PEN_FIRST : PEN_SECOND;
            PEN_SECOND: state_nx = misp ? PEN_FIRST : PEN_IDLE;
            default:    state_nx = PEN_IDLE;
        endcase
    end

    // Penalty state machine: outputs
    always_comb begin
        flush    = 1'b0;
        redirect = 1'b0;
        unique case (state)
            PEN_IDLE:   ;
            PEN_FIRST:  begin flush = 1'b1; redirect = 1'b1; end
            PEN_SECOND: flush = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 4,
    parameter int PC_STEP = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    fetch_pc,
    input logic               pred_hit,
    input logic [PC_W-1:0]    pred_next_pc,
    input logic               res_valid,
    input logic               res_taken,
    input logic [PC_W-1:0]    res_target,
    input logic               flush,
    input logic               redirect,
    input logic [PC_W-1:0]    redirect_pc,
    input logic               misp,
    input logic               up_hit,
    input logic [ENTRIES-1:0] lk_vec
);
    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> pred_next_pc == fetch_pc + PC_W'(PC_STEP)); // R1
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec)); // R1
    AST_TAKEN_MISS_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_taken && !up_hit |=> redirect && redirect_pc == $past(res_target)); // R3
    AST_DELETE_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_taken && up_hit |=> redirect); // R5
    AST_REDIR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> flush); // R8
    AST_SECOND_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
        redirect && !misp |=> flush && !redirect); // R8
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        flush && misp |=> redirect); // R9
endmodule

bind btb_top btb_chk #(.PC_W(PC_W), .ENTRIES(ENTRIES), .PC_STEP(PC_STEP)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_next_pc(pred_next_pc), .res_valid(res_valid), .res_taken(res_taken),
    .res_target(res_target), .flush(flush), .redirect(redirect),
    .redirect_pc(redirect_pc), .misp(misp), .up_hit(up_hit), .lk_vec(lk_vec)
);

// File: tb/sim_btb_top.sv
`timescale 1ns/1ps
module sim_btb_top;
    localparam int W = 32;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] fetch_pc = '0;
    logic         pred_hit;
    logic [W-1:0] pred_next_pc;
    logic         res_valid = 1'b0;
    logic [W-1:0] res_pc = '0;
    logic         res_taken = 1'b0;
    logic [W-1:0] res_target = '0;
    logic         flush, redirect;
    logic [W-1:0] redirect_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit           m_v   [N];
    logic [W-1:0] m_tag [N];
    logic [W-1:0] m_tgt [N];
    int           m_rr  = 0;
    int           m_pen = 0;
    logic [W-1:0] m_rpc = '0;

    always #2.5 clk = ~clk;

    btb_top #(.PC_W(W), .ENTRIES(N), .PC_STEP(4)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
        .pred_next_pc(pred_next_pc), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_target(res_target), .flush(flush),
        .redirect(redirect), .redirect_pc(redirect_pc)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int find(logic [W-1:0] pc);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    task automatic compare();
        int k;
        k = find(fetch_pc);
        if (k >= 0) begin
            chk("R2 hit", W'(pred_hit), W'(1));
            chk("R2 target", pred_next_pc, m_tgt[k]);
        end else begin
            chk("R1 miss", W'(pred_hit), W'(0));
            chk("R1 seq", pred_next_pc, fetch_pc + 4);
        end
        chk("R8 flush", W'(flush), W'(m_pen != 0));
        chk("R8 redirect", W'(redirect), W'(m_pen == 1));
        if (m_pen == 1) chk("R8 redirect_pc", redirect_pc, m_rpc);
    endtask

    task automatic advance();
        int k;
        bit mp;
        k  = find(res_pc);
        mp = 0;
        if (res_valid) begin
            if (k >= 0 && !res_taken) begin
                mp = 1; m_v[k] = 0;
            end else if (k >= 0) begin
                if (m_tgt[k] != res_target) begin mp = 1; m_tgt[k] = res_target; end
            end else if (res_taken) begin
                int s;
                mp = 1; s = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
                if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % N; end
                m_v[s] = 1; m_tag[s] = res_pc; m_tgt[s] = res_target;
            end
        end
        if (mp) begin
            m_pen = 1;
            m_rpc = res_taken ? res_target : res_pc + 4;
        end else if (m_pen == 1) m_pen = 2;
        else m_pen = 0;
    endtask

    task automatic cyc(logic [W-1:0] lk, bit uv = 0, logic [W-1:0] upc = '0,
                       bit ut = 0, logic [W-1:0] utgt = '0);
        fetch_pc = lk; res_valid = uv; res_pc = upc; res_taken = ut; res_target = utgt;
        @(negedge clk);
        compare();
        @(posedge clk);
        advance();
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: empty table, quiet penalty outputs
        cyc(32'h100);
        // R3 insert; R10 same-cycle lookup sees old (miss)
        cyc(32'h100, 1, 32'h100, 1, 32'h400);
        cyc(32'h100);                       // R2 hit, R8 redirect
        cyc(32'h80000100);                  // R1 high-bit difference misses
        cyc(32'h104);
        // R7 no-change cases
        cyc(32'h100, 1, 32'h100, 1, 32'h400);
        cyc(32'h200, 1, 32'h200, 0, 32'h0);
        cyc(32'h100);
        // R6 destination rewrite
        cyc(32'h100, 1, 32'h100, 1, 32'h500);
        cyc(32'h100);
        cyc(32'h100);
        // R9 back-to-back insertions restart the penalty
        cyc(32'h110, 1, 32'h110, 1, 32'h1110);
        cyc(32'h110, 1, 32'h120, 1, 32'h1120);
        cyc(32'h120, 1, 32'h130, 1, 32'h1130);
        cyc(32'h130);
        cyc(32'h130);
        // R4 table full: round-robin victim 0 then 1
        cyc(32'h140, 1, 32'h140, 1, 32'h1140);
        cyc(32'h100);
        cyc(32'h140, 1, 32'h150, 1, 32'h1150);
        cyc(32'h110);
        // R5 delete; R10 lookup of same address in that cycle still hits
        cyc(32'h120, 1, 32'h120, 0, 32'h0);
        cyc(32'h120);
        cyc(32'h120);
        // R4 free entry preferred over pointer, then pointer resumes at 2
        cyc(32'h160, 1, 32'h160, 1, 32'h1160);
        cyc(32'h160);
        cyc(32'h170, 1, 32'h170, 1, 32'h1170);
        cyc(32'h160);
        cyc(32'h170);
        cyc(32'h130);
        repeat (3) cyc(32'h150);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule